// File: doc/BRIEF.md
# Multi-Port Register File Coupling-Fault Self-Test Sequencer

This block is a built-in self-test controller for a register file with several dedicated read ports and several dedicated write ports. After a start pulse it fills the array with an all-ones background through write port 0. It then sweeps every row as the victim row and runs four short test sequences against it. The sequences target coupling on read word lines and read bit lines, on write word lines, on the shared (global) word line, and on write bit lines. In the aggressor cycle of each sequence, every other port of the memory operates at the same moment. These ports hit the victim row, the next row, the previous row or the very same cell.

One row/column generator and one data generator serve every port. Each port only chooses a row offset (same row, next row, previous row) and a column (base column or base plus one). The write data is always a solid all-zeros or all-ones word, so concurrent ports drive their bit lines opposite to the value the read port under test expects. Read data returns one cycle after the request. It is checked against an expected value that is held in a register for that cycle. The first mismatch latches a sticky fail flag together with the read port, row and column involved.

Top module: `mprf_bist`

## Requirements
- R1: While reset is asserted and after its release, until a start is accepted, `busy`, `done` and `fail` are low and no port is enabled.
- R2: A start pulse while idle or done makes `busy` high from the next cycle. The first ROWS*COLS busy cycles are an initialization pass. In it only write port 0 is enabled, it writes an all-ones word, and it visits cells row-major from row 0, column 0 (cycle k writes row k/COLS, column k%COLS).
- R3: Read word/bit line sequence, per victim read port p and row n in 0..ROWS-2 (four cycles): write port 0 writes 0 to (n,0); write port 0 writes 1 to (n+1,0); port p reads (n,0) expecting 0; port p reads (n+1,0) expecting 1, while all write ports write 0 to (n,0) and all other read ports read (n,0) expecting 0.
- R4: Write word line sequence, per victim write port w and row n in 0..ROWS-2 (three cycles): w writes 0 to (n,0); w writes 1 to (n+1,0), while all other write ports write 0 to (n,0) and all read ports read (n,0) expecting 0; read port w mod NRD reads (n,0) expecting 0.
- R5: Global word line sequence, per victim write port w and row n in 0..ROWS-2: w writes 1 to (n,0); w writes 0 to (n+1,0), while all other write ports write 0 to (n,1) and all read ports read (n,0) expecting 1; read port w mod NRD reads (n,0) expecting 1.
- R6: Write bit line sequence, per victim write port w and row n in 1..ROWS-1: w writes 1 to (n,0); w writes 0 to (n,0), while all other write ports write 1 to (n-1,0) and all read ports read (n-1,0) without compare; read port w mod NRD reads (n,0) expecting 0.
- R7: The sequences run in the order R3, R4, R5, R6, with victim ports ascending and, inside each port, rows ascending. Rows whose n+1 or n-1 falls outside the array are skipped. A run is busy for exactly ROWS*COLS + 4*NRD*(ROWS-1) + 9*NWR*(ROWS-1) + 1 cycles.
- R8: Every enabled write port carries an all-zeros or all-ones word. All write ports are enabled together in NRD*(ROWS-1) + 3*NWR*(ROWS-1) cycles of a run, and all read ports are enabled together in the same number of cycles.
- R9: A compared read is checked on the cycle after it is issued. The first mismatch sets `fail`, which stays set until the next accepted start. The lowest mismatching read port index goes to `fail_port`, and the read's row and column go to `fail_row` and `fail_col`.
- R10: After the last check `done` rises with `busy` low and holds until the next start. A start while busy is ignored. No port is enabled while not busy.
- R11: A start accepted from done clears `fail` in the first busy cycle and runs the whole test again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Start pulse, taken while idle or done |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test complete, held until next start |
| fail | output | 1 | Sticky mismatch flag |
| fail_port | output | PIW | Read port of the first mismatch |
| fail_row | output | RAW | Row of the first mismatch |
| fail_col | output | CAW | Column of the first mismatch |
| wr_en | output | NWR | Write enable per write port |
| wr_row | output | NWR*RAW | Write row per port, port i at bits [i*RAW +: RAW] |
| wr_col | output | NWR*CAW | Write column per port |
| wr_data | output | NWR*DW | Write word per port |
| rd_en | output | NRD | Read enable per read port |
| rd_row | output | NRD*RAW | Read row per port |
| rd_col | output | NRD*CAW | Read column per port |
| rd_data | input | NRD*DW | Read word per port, valid the cycle after the request |

## Verification
The bench builds the block with three read ports, two write ports, eight rows, four columns and an 8-bit word. With unequal port counts the read-side and write-side sweeps differ in length. Write port 1 pairs with read port 1 while read port 2 only ever acts as an aggressor, and four columns make the init pass visit columns beyond the two the tests use. A behavioural memory with read-before-write behaviour injects one coupling fault at a time, each reachable only by its own sequence. This shows that each sequence's aggressor cycle actually lines up the victim and aggressor ports, and that the reported port and row are the ones of that sequence.

// File: rtl/mprf_bist_pkg.sv
package mprf_bist_pkg;

  typedef enum logic [2:0] {PH_IDLE, PH_INIT, PH_RUN, PH_DRAIN, PH_DONE} phase_e;
  typedef enum logic [1:0] {K_RWL, K_WWL, K_GWL, K_WBL} kind_e;
  typedef enum logic [1:0] {OFF_SAME, OFF_NEXT, OFF_PREV} roff_e;

  typedef struct packed {
    logic  en;
    roff_e off;
    logic  col1;
    logic  val;
  } wop_t;

  typedef struct packed {
    logic  en;
    roff_e off;
    logic  cmp;
    logic  exp;
  } rop_t;

  typedef struct packed {
    wop_t wv;
    wop_t wo;
    rop_t rv;
    rop_t ro;
  } cyc_op_t;

  function automatic wop_t mk_w(roff_e off, logic col1, logic val);
    wop_t w;
    w.en = 1'b1; w.off = off; w.col1 = col1; w.val = val;
    return w;
  endfunction

  function automatic rop_t mk_r(roff_e off, logic cmp, logic exp);
    rop_t r;
    r.en = 1'b1; r.off = off; r.cmp = cmp; r.exp = exp;
    return r;
  endfunction

  // Per-step role table of the four coupling sequences.
  function automatic cyc_op_t decode_step(kind_e k, logic [1:0] s);
    cyc_op_t o;
    o = '0;
    case (k)
      K_RWL: begin
        case (s)
          2'd0: o.wv = mk_w(OFF_SAME, 1'b0, 1'b0);
          2'd1: o.wv = mk_w(OFF_NEXT, 1'b0, 1'b1);
          2'd2: o.rv = mk_r(OFF_SAME, 1'b1, 1'b0);
          default: begin
            o.rv = mk_r(OFF_NEXT, 1'b1, 1'b1);
            o.wv = mk_w(OFF_SAME, 1'b0, 1'b0);
            o.wo = mk_w(OFF_SAME, 1'b0, 1'b0);
            o.ro = mk_r(OFF_SAME, 1'b1, 1'b0);
          end
        endcase
      end
      K_WWL: begin
        case (s)
          2'd0: o.wv = mk_w(OFF_SAME, 1'b0, 1'b0);
          2'd1: begin
            o.wv = mk_w(OFF_NEXT, 1'b0, 1'b1);
            o.wo = mk_w(OFF_SAME, 1'b0, 1'b0);
            o.rv = mk_r(OFF_SAME, 1'b1, 1'b0);
            o.ro = mk_r(OFF_SAME, 1'b1, 1'b0);
          end
          default: o.rv = mk_r(OFF_SAME, 1'b1, 1'b0);
        endcase
      end
      K_GWL: begin
        case (s)
          2'd0: o.wv = mk_w(OFF_SAME, 1'b0, 1'b1);
          2'd1: begin
            o.wv = mk_w(OFF_NEXT, 1'b0, 1'b0);
            o.wo = mk_w(OFF_SAME, 1'b1, 1'b0);
            o.rv = mk_r(OFF_SAME, 1'b1, 1'b1);
            o.ro = mk_r(OFF_SAME, 1'b1, 1'b1);
          end
          default: o.rv = mk_r(OFF_SAME, 1'b1, 1'b1);
        endcase
      end
      default: begin
        case (s)
          2'd0: o.wv = mk_w(OFF_SAME, 1'b0, 1'b1);
          2'd1: begin
            o.wv = mk_w(OFF_SAME, 1'b0, 1'b0);
            o.wo = mk_w(OFF_PREV, 1'b0, 1'b1);
            o.rv = mk_r(OFF_PREV, 1'b0, 1'b0);
            o.ro = mk_r(OFF_PREV, 1'b0, 1'b0);
          end
          default: o.rv = mk_r(OFF_SAME, 1'b1, 1'b0);
        endcase
      end
    endcase
    return o;
  endfunction

endpackage

// File: rtl/mprf_bist_seq.sv
module mprf_bist_seq
  import mprf_bist_pkg::*;
#(
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  parameter int ROWS = 8,
  parameter int COLS = 4,
  localparam int RAW = (ROWS > 2) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 2) ? $clog2(COLS) : 1,
  localparam int PMX = (NRD > NWR) ? NRD : NWR,
  localparam int PIW = (PMX > 2) ? $clog2(PMX) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           busy,
  output logic           done,
  output logic           clr,
  output cyc_op_t        op,
  output logic [RAW-1:0] base_row,
  output logic [CAW-1:0] base_col,
  output logic [PIW-1:0] wv_idx,
  output logic [PIW-1:0] rv_idx
);

  localparam logic [RAW-1:0] ROW_LAST = RAW'(ROWS - 1);
  localparam logic [RAW-1:0] ROW_PEN  = RAW'(ROWS - 2);
  localparam logic [CAW-1:0] COL_LAST = CAW'(COLS - 1);
  localparam logic [PIW-1:0] RD_LAST  = PIW'(NRD - 1);
  localparam logic [PIW-1:0] WR_LAST  = PIW'(NWR - 1);

  phase_e         phase_q, phase_d;
  kind_e          kind_q, kind_d;
  logic [PIW-1:0] port_q, port_d;
  logic [RAW-1:0] row_q, row_d;
  logic [CAW-1:0] col_q, col_d;
  logic [1:0]     step_q, step_d;
  logic           seq_en;
  logic           idle_like;
  logic           step_last, row_last, port_last;

  function automatic logic [RAW-1:0] first_row(kind_e k);
    return (k == K_WBL) ? RAW'(1) : '0;
  endfunction

  assign idle_like = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
  assign clr       = idle_like && start;
  assign seq_en    = !idle_like || start;

  assign step_last = (kind_q == K_RWL) ? (step_q == 2'd3) : (step_q == 2'd2);
  assign row_last  = (kind_q == K_WBL) ? (row_q == ROW_LAST) : (row_q == ROW_PEN);
  assign port_last = (kind_q == K_RWL) ? (port_q == RD_LAST) : (port_q == WR_LAST);

  always_comb begin
    phase_d = phase_q;
    kind_d  = kind_q;
    port_d  = port_q;
    row_d   = row_q;
    col_d   = col_q;
    step_d  = step_q;
    case (phase_q)
      PH_IDLE, PH_DONE: begin
        if (start) begin
          phase_d = PH_INIT;
          kind_d  = K_RWL;
          port_d  = '0;
          row_d   = '0;
          col_d   = '0;
          step_d  = '0;
        end
      end
      PH_INIT: begin
        if (col_q == COL_LAST) begin
          col_d = '0;
          if (row_q == ROW_LAST) begin
            phase_d = PH_RUN;
            row_d   = first_row(K_RWL);
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          col_d = col_q + 1'b1;
        end
      end
      PH_RUN: begin
        if (step_last) begin
          step_d = '0;
          if (row_last) begin
            if (port_last) begin
              port_d = '0;
              if (kind_q == K_WBL) begin
                phase_d = PH_DRAIN;
              end else begin
                kind_d = kind_e'(kind_q + 2'd1);
                row_d  = first_row(kind_e'(kind_q + 2'd1));
              end
            end else begin
              port_d = port_q + 1'b1;
              row_d  = first_row(kind_q);
            end
          end else begin
            row_d = row_q + 1'b1;
          end
        end else begin
          step_d = step_q + 2'd1;
        end
      end
      PH_DRAIN: phase_d = PH_DONE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      kind_q  <= K_RWL;
      port_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      step_q  <= '0;
    end else if (seq_en) begin
      phase_q <= phase_d;
      kind_q  <= kind_d;
      port_q  <= port_d;
      row_q   <= row_d;
      col_q   <= col_d;
      step_q  <= step_d;
    end
  end

  assign busy = (phase_q == PH_INIT) || (phase_q == PH_RUN) || (phase_q == PH_DRAIN);
  assign done = (phase_q == PH_DONE);

  always_comb begin
    op = '0;
    if (phase_q == PH_RUN) begin
      op = decode_step(kind_q, step_q);
    end else if (phase_q == PH_INIT) begin
      op.wv = mk_w(OFF_SAME, 1'b0, 1'b1);
    end
  end

  assign base_row = row_q;
  assign base_col = (phase_q == PH_INIT) ? col_q : '0;
  assign wv_idx   = ((phase_q == PH_RUN) && (kind_q != K_RWL)) ? port_q : '0;
  assign rv_idx   = (kind_q == K_RWL) ? port_q : PIW'(port_q % NRD);

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle_like) |=> busy); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R10

endmodule

// File: rtl/mprf_bist_portmux.sv
module mprf_bist_portmux
  import mprf_bist_pkg::*;
#(
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  parameter int ROWS = 8,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int RAW = (ROWS > 2) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 2) ? $clog2(COLS) : 1,
  localparam int PMX = (NRD > NWR) ? NRD : NWR,
  localparam int PIW = (PMX > 2) ? $clog2(PMX) : 1
) (
  input  cyc_op_t            op,
  input  logic [RAW-1:0]     base_row,
  input  logic [CAW-1:0]     base_col,
  input  logic [PIW-1:0]     wv_idx,
  input  logic [PIW-1:0]     rv_idx,
  output logic [NWR-1:0]     wr_en,
  output logic [NWR*RAW-1:0] wr_row,
  output logic [NWR*CAW-1:0] wr_col,
  output logic [NWR*DW-1:0]  wr_data,
  output logic [NRD-1:0]     rd_en,
  output logic [NRD*RAW-1:0] rd_row,
  output logic [NRD*CAW-1:0] rd_col,
  output logic [NRD-1:0]     rd_cmp,
  output logic [NRD-1:0]     rd_exp
);

  // Shared address generator: three row candidates and two column candidates.
  logic [RAW-1:0] row_same, row_next, row_prev;
  logic [CAW-1:0] col_base, col_plus;

  assign row_same = base_row;
  assign row_next = base_row + 1'b1;
  assign row_prev = base_row - 1'b1;
  assign col_base = base_col;
  assign col_plus = base_col + 1'b1;

  function automatic logic [RAW-1:0] pick_row(roff_e off, logic [RAW-1:0] rs,
                                              logic [RAW-1:0] rn, logic [RAW-1:0] rp);
    case (off)
      OFF_NEXT: return rn;
      OFF_PREV: return rp;
      default:  return rs;
    endcase
  endfunction

  for (genvar gi = 0; gi < NWR; gi++) begin : g_wr
    wop_t sel;
    always_comb begin
      sel = (wv_idx == PIW'(gi)) ? op.wv : op.wo;
    end
    assign wr_en[gi]                = sel.en;
    assign wr_row[gi*RAW +: RAW]    = pick_row(sel.off, row_same, row_next, row_prev);
    assign wr_col[gi*CAW +: CAW]    = sel.col1 ? col_plus : col_base;
    assign wr_data[gi*DW +: DW]     = {DW{sel.val}};
  end

  for (genvar gr = 0; gr < NRD; gr++) begin : g_rd
    rop_t sel;
    always_comb begin
      sel = (rv_idx == PIW'(gr)) ? op.rv : op.ro;
    end
    assign rd_en[gr]             = sel.en;
    assign rd_row[gr*RAW +: RAW] = pick_row(sel.off, row_same, row_next, row_prev);
    assign rd_col[gr*CAW +: CAW] = col_base;
    assign rd_cmp[gr]            = sel.en && sel.cmp;
    assign rd_exp[gr]            = sel.exp;
  end

endmodule

// File: rtl/mprf_bist_cmp.sv
module mprf_bist_cmp #(
  parameter int NRD = 3,
  parameter int RAW = 3,
  parameter int CAW = 2,
  parameter int DW  = 8,
  parameter int PIW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [NRD-1:0]     iss_cmp,
  input  logic [NRD-1:0]     iss_exp,
  input  logic [NRD*RAW-1:0] iss_row,
  input  logic [NRD*CAW-1:0] iss_col,
  input  logic [NRD*DW-1:0]  rd_data,
  output logic               fail,
  output logic [PIW-1:0]     fail_port,
  output logic [RAW-1:0]     fail_row,
  output logic [CAW-1:0]     fail_col
);

  logic [NRD-1:0]     cmp_q, exp_q, mism;
  logic [NRD*RAW-1:0] row_q;
  logic [NRD*CAW-1:0] col_q;
  logic               fail_q, fail_d;
  logic [PIW-1:0]     port_q, port_d;
  logic [RAW-1:0]     frow_q, frow_d;
  logic [CAW-1:0]     fcol_q, fcol_d;
  logic               cap;

  // Expected values held for the one-cycle read latency.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      exp_q <= '0;
      row_q <= '0;
      col_q <= '0;
    end else begin
      cmp_q <= clr ? '0 : iss_cmp;
      exp_q <= iss_exp;
      row_q <= iss_row;
      col_q <= iss_col;
    end
  end

  for (genvar gp = 0; gp < NRD; gp++) begin : g_cmp
    assign mism[gp] = cmp_q[gp] && (rd_data[gp*DW +: DW] != {DW{exp_q[gp]}});
  end

  always_comb begin
    port_d = port_q;
    frow_d = frow_q;
    fcol_d = fcol_q;
    cap    = !fail_q && (|mism);
    for (int i = NRD - 1; i >= 0; i--) begin
      if (mism[i]) begin
        port_d = PIW'(i);
        frow_d = row_q[i*RAW +: RAW];
        fcol_d = col_q[i*CAW +: CAW];
      end
    end
    fail_d = fail_q || cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      port_q <= '0;
      frow_q <= '0;
      fcol_q <= '0;
    end else if (clr) begin
      fail_q <= 1'b0;
      port_q <= '0;
      frow_q <= '0;
      fcol_q <= '0;
    end else if (cap) begin
      fail_q <= fail_d;
      port_q <= port_d;
      frow_q <= frow_d;
      fcol_q <= fcol_d;
    end
  end

  assign fail      = fail_q;
  assign fail_port = port_q;
  assign fail_row  = frow_q;
  assign fail_col  = fcol_q;

  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> fail_q); // R9
  AST_FAIL_INFO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clr) |=> ($stable(frow_q) && $stable(port_q))); // R9

endmodule

// File: rtl/mprf_bist.sv
module mprf_bist
  import mprf_bist_pkg::*;
#(
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  parameter int ROWS = 8,
  parameter int COLS = 4,
  parameter int DW   = 8,
  localparam int RAW = (ROWS > 2) ? $clog2(ROWS) : 1,
  localparam int CAW = (COLS > 2) ? $clog2(COLS) : 1,
  localparam int PMX = (NRD > NWR) ? NRD : NWR,
  localparam int PIW = (PMX > 2) ? $clog2(PMX) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [PIW-1:0]     fail_port,
  output logic [RAW-1:0]     fail_row,
  output logic [CAW-1:0]     fail_col,
  output logic [NWR-1:0]     wr_en,
  output logic [NWR*RAW-1:0] wr_row,
  output logic [NWR*CAW-1:0] wr_col,
  output logic [NWR*DW-1:0]  wr_data,
  output logic [NRD-1:0]     rd_en,
  output logic [NRD*RAW-1:0] rd_row,
  output logic [NRD*CAW-1:0] rd_col,
  input  logic [NRD*DW-1:0]  rd_data
);

  logic [1:0]     rsync_q;
  logic           rst_core_n;
  logic           clr;
  cyc_op_t        op;
  logic [RAW-1:0] base_row;
  logic [CAW-1:0] base_col;
  logic [PIW-1:0] wv_idx, rv_idx;
  logic [NRD-1:0] rd_cmp, rd_exp;

  // Reset asserts at once, deasserts after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  mprf_bist_seq #(
    .NRD(NRD), .NWR(NWR), .ROWS(ROWS), .COLS(COLS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .clr      (clr),
    .op       (op),
    .base_row (base_row),
    .base_col (base_col),
    .wv_idx   (wv_idx),
    .rv_idx   (rv_idx)
  );

  mprf_bist_portmux #(
    .NRD(NRD), .NWR(NWR), .ROWS(ROWS), .COLS(COLS), .DW(DW)
  ) u_mux (
    .op       (op),
    .base_row (base_row),
    .base_col (base_col),
    .wv_idx   (wv_idx),
    .rv_idx   (rv_idx),
    .wr_en    (wr_en),
    .wr_row   (wr_row),
    .wr_col   (wr_col),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_row   (rd_row),
    .rd_col   (rd_col),
    .rd_cmp   (rd_cmp),
    .rd_exp   (rd_exp)
  );

  mprf_bist_cmp #(
    .NRD(NRD), .RAW(RAW), .CAW(CAW), .DW(DW), .PIW(PIW)
  ) u_cmp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (clr),
    .iss_cmp   (rd_cmp),
    .iss_exp   (rd_exp),
    .iss_row   (rd_row),
    .iss_col   (rd_col),
    .rd_data   (rd_data),
    .fail      (fail),
    .fail_port (fail_port),
    .fail_row  (fail_row),
    .fail_col  (fail_col)
  );

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(busy && done)); // R10
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !busy |-> ((wr_en == '0) && (rd_en == '0))); // R10

endmodule

// File: tb/tb_mprf_bist.sv
module tb_mprf_bist;

  localparam int CLK_PERIOD = 10;
  localparam int NRD  = 3;
  localparam int NWR  = 2;
  localparam int ROWS = 8;
  localparam int COLS = 4;
  localparam int DW   = 8;
  localparam int RAW  = 3;
  localparam int CAW  = 2;
  localparam int PIW  = 2;
  localparam int FR   = 3;
  localparam int WDOG = 200000;
  localparam int EXP_CYC  = ROWS*COLS + 4*NRD*(ROWS-1) + 9*NWR*(ROWS-1) + 1;
  localparam int EXP_ALLP = NRD*(ROWS-1) + 3*NWR*(ROWS-1);

  logic               clk;
  logic               rst_n;
  logic               start;
  logic               busy, done, fail;
  logic [PIW-1:0]     fail_port;
  logic [RAW-1:0]     fail_row;
  logic [CAW-1:0]     fail_col;
  logic [NWR-1:0]     wr_en;
  logic [NWR*RAW-1:0] wr_row;
  logic [NWR*CAW-1:0] wr_col;
  logic [NWR*DW-1:0]  wr_data;
  logic [NRD-1:0]     rd_en;
  logic [NRD*RAW-1:0] rd_row;
  logic [NRD*CAW-1:0] rd_col;
  logic [NRD*DW-1:0]  rd_data;

  mprf_bist #(.NRD(NRD), .NWR(NWR), .ROWS(ROWS), .COLS(COLS), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_port(fail_port), .fail_row(fail_row), .fail_col(fail_col),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk;
  int n_bad;
  int fmode;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Behavioural array, read-before-write, one-cycle read latency, fault hooks.
  logic [DW-1:0] mem [ROWS][COLS];

  always @(posedge clk) begin : mem_model
    logic [DW-1:0] d;
    logic [DW-1:0] keep;
    bit            hit;
    int            r, c;
    for (int i = 0; i < NRD; i++) begin
      if (rd_en[i]) begin
        r = int'(rd_row[i*RAW +: RAW]);
        c = int'(rd_col[i*CAW +: CAW]);
        d = mem[r][c];
        if (fmode == 2 && i == 1 && r == FR + 1) begin
          hit = 0;
          for (int j = 0; j < NWR; j++)
            if (wr_en[j] && int'(wr_row[j*RAW +: RAW]) == FR) hit = 1;
          if (hit) d = ~d;
        end
        rd_data[i*DW +: DW] <= d;
      end
    end
    keep = mem[FR][0];
    for (int j = 0; j < NWR; j++)
      if (wr_en[j]) mem[int'(wr_row[j*RAW +: RAW])][int'(wr_col[j*CAW +: CAW])] = wr_data[j*DW +: DW];
    if (wr_en[0] && int'(wr_col[0 +: CAW]) == 0) begin
      hit = 0;
      for (int j = 1; j < NWR; j++) begin
        if (wr_en[j]) begin
          r = int'(wr_row[j*RAW +: RAW]);
          c = int'(wr_col[j*CAW +: CAW]);
          if (fmode == 1 && int'(wr_row[0 +: RAW]) == FR + 1 && r == FR) hit = 1;
          if (fmode == 4 && int'(wr_row[0 +: RAW]) == FR + 1 && r == FR && c == 1) hit = 1;
          if (fmode == 3 && int'(wr_row[0 +: RAW]) == FR && r == FR - 1 && c == 0 &&
              wr_data[j*DW +: DW] == {DW{1'b1}}) hit = 1;
        end
      end
      if (hit && fmode == 1) mem[FR][0] = wr_data[0 +: DW];
      if (hit && fmode == 4) mem[FR][0] = '0;
      if (hit && fmode == 3) mem[FR][0] = keep;
    end
  end

  typedef struct {
    int mode;
    bit efail;
    int eport;
    int erow;
    string req;
  } exp_t;
  exp_t sbq[$];

  // Monitor: per-run statistics and scoreboard pop on done.
  int  busy_cnt, init_bad, data_bad, allw, allr;
  bit  busy_p, done_p;

  always @(negedge clk) begin : monitor
    exp_t e;
    if (!rst_n) begin
      busy_p = 0; done_p = 0;
    end else begin
      if (busy && !busy_p) begin
        busy_cnt = 0; init_bad = 0; data_bad = 0; allw = 0; allr = 0;
        chk(fail == 1'b0, "R11 fail cleared on restart", int'(fail), 0);
        chk(done == 1'b0, "R11 done dropped on restart", int'(done), 0);
      end
      if (busy) begin
        if (busy_cnt < ROWS*COLS) begin
          if (wr_en != NWR'(1) || rd_en != '0 || wr_data[0 +: DW] != {DW{1'b1}} ||
              int'(wr_row[0 +: RAW]) != busy_cnt / COLS ||
              int'(wr_col[0 +: CAW]) != busy_cnt % COLS) init_bad++;
        end
        for (int j = 0; j < NWR; j++)
          if (wr_en[j] && wr_data[j*DW +: DW] != '0 && wr_data[j*DW +: DW] != {DW{1'b1}})
            data_bad++;
        if (&wr_en) allw++;
        if (&rd_en) allr++;
        busy_cnt++;
      end
      if (done && !done_p) begin
        if (sbq.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          e = sbq.pop_front();
          chk(!busy, "R10 busy low at done", int'(busy), 0);
          chk(busy_cnt == EXP_CYC, "R7 busy cycles", busy_cnt, EXP_CYC);
          chk(init_bad == 0, "R2 init pass", init_bad, 0);
          chk(data_bad == 0, "R8 solid write words", data_bad, 0);
          chk(allw == EXP_ALLP, "R8 all write ports together", allw, EXP_ALLP);
          chk(allr == EXP_ALLP, "R8 all read ports together", allr, EXP_ALLP);
          chk(fail == e.efail, {e.req, " fail flag"}, int'(fail), int'(e.efail));
          if (e.efail) begin
            chk(int'(fail_port) == e.eport, {e.req, " R9 fail_port"}, int'(fail_port), e.eport);
            chk(int'(fail_row) == e.erow, {e.req, " R9 fail_row"}, int'(fail_row), e.erow);
            chk(fail_col == '0, {e.req, " R9 fail_col"}, int'(fail_col), 0);
          end
        end
      end
      busy_p = busy;
      done_p = done;
    end
  end

  // Driver: push the expected outcome, pulse start, wait for completion.
  task automatic run_case(input int mode, input bit efail, input int eport,
                          input int erow, input string req, input bit poke);
    exp_t e;
    e.mode = mode; e.efail = efail; e.eport = eport; e.erow = erow; e.req = req;
    fmode = mode;
    sbq.push_back(e);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R10 done holds", int'(done), 1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; fmode = 0;
    start = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && fail == 1'b0, "R1 outputs in reset",
        int'({busy, done, fail}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && fail == 1'b0, "R1 outputs after reset",
        int'({busy, done, fail}), 0);
    chk(wr_en == '0 && rd_en == '0, "R1 ports quiet", int'({wr_en, rd_en}), 0);
    fork
      begin
        run_case(0, 1'b0, 0, 0, "R3 R4 R5 R6 clean array", 1'b0);
        run_case(2, 1'b1, 1, FR + 1, "R3 read word line fault", 1'b0);
        run_case(1, 1'b1, 0, FR, "R4 write word line fault", 1'b0);
        run_case(4, 1'b1, 0, FR, "R5 global word line fault", 1'b0);
        run_case(3, 1'b1, 0, FR, "R6 write bit line fault", 1'b0);
        run_case(0, 1'b0, 0, 0, "R10 start while busy ignored", 1'b1);
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R10 all runs completed", sbq.size(), 0);
      end
      begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule